// File: doc/BRIEF.md
# Filtered Frame Clock Ratio Tracker

This block watches two free-running audio frame clocks, one on the producing side of a rate converter and one on the consuming side. It brings both into a single master clock domain and measures each frame period in master cycles. It then turns the two periods into a smoothed estimate of how fast input frames arrive relative to output frames. A later polyphase stage uses this estimate to choose interpolation phases. That stage is not part of this block.

Each period stream goes through its own first-order exponential average. Both averages use the same time constant, so input-side and output-side timing noise are weighted alike. One input selects that time constant, trading jitter rejection against tracking speed. After every output frame, a bit-serial divider forms the ratio of the two averages. The result is an unsigned fixed-point value with 2 integer and 20 fractional bits. It comes with a valid flag and a flag for ratios outside the supported 1:2 to 2:1 window.

Top module: `ratio_tracker`

## Requirements
- R1: While `rst` is high and after it falls, until the first ratio is produced, `ratio_o`, `ratio_valid_o` and `out_of_range_o` are all zero.
- R2: Each frame clock passes through a two-flop synchronizer, and each rising edge yields one frame event. The period of a frame is the number of master cycles between two successive events. With constant periods Pin (input) and Pout (output), `ratio_o` settles to exactly floor(Pout * 2^20 / Pin), read as 2 integer bits above 20 fractional bits.
- R3: The first event on a clock only starts measurement. The first complete period is loaded into that clock's average directly. With equal constant periods, the first ratio produced is already exactly 0x100000.
- R4: On each new period P, the average A (held with 8 fractional bits) becomes A + ((P*256 - A) >>> k). k is SLOW_SHIFT (6) when `fast_settle_i` is 0 and FAST_SHIFT (4) when it is 1, and the same k applies to both clocks.
- R5: A new ratio floor(Aout * 2^20 / Ain) is computed after each output frame event, and only once both averages are loaded. It appears on `ratio_o` within 50 master cycles of that event. Before both averages are loaded, `ratio_o` keeps its reset value.
- R6: A quotient of 4.0 or more saturates `ratio_o` to 0x3FFFFF.
- R7: A period longer than 4095 master cycles is measured as 4095.
- R8: `ratio_valid_o` rises with the fourth ratio produced after reset and stays high until the next reset.
- R9: `out_of_range_o` is high exactly when `ratio_valid_o` is high and `ratio_o` is below 0x080000 (0.5) or above 0x200000 (2.0). The values 0.5 and 2.0 themselves count as in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_in_i | input | 1 | Frame clock of the input sample stream, asynchronous |
| frame_out_i | input | 1 | Frame clock of the output sample stream, asynchronous |
| fast_settle_i | input | 1 | 1 selects the short averaging time constant, 0 the long one |
| ratio_o | output | 22 | Filtered input/output rate ratio, unsigned, 2 integer and 20 fraction bits |
| ratio_valid_o | output | 1 | Ratio estimate has been produced enough times to be used |
| out_of_range_o | output | 1 | Valid ratio lies outside 0.5 to 2.0 |

## Verification
A corrupted period average shows up on `ratio_o` at the next output frame event plus the divider latency, under 50 master cycles later. Because every division reads a fresh snapshot, a wrong value persists only as long as the average itself stays wrong. A fault in the averaging shift or the loading of the first period breaks the exact steady-state and step-response values after a handful of output frames. A miscounted divider iteration gives a wrong quotient on every single result. A wrong result counter or range comparison shows at the fourth result after reset, or at the first ratio that crosses 0.5 or 2.0.

// File: rtl/ratio_trk_pkg.sv
package ratio_trk_pkg;

    localparam int RATIO_INT  = 2;
    localparam int RATIO_FRAC = 20;
    localparam int RATIO_W    = RATIO_INT + RATIO_FRAC;

    typedef logic [RATIO_W-1:0] ratio_t;

    localparam ratio_t RATIO_HALF = ratio_t'(1) << (RATIO_FRAC - 1);
    localparam ratio_t RATIO_TWO  = ratio_t'(1) << (RATIO_FRAC + 1);
    localparam ratio_t RATIO_SAT  = '1;

    typedef struct packed {
        ratio_t value;
        logic   outside;
    } ratio_res_t;

    typedef enum logic {
        DIV_IDLE,
        DIV_RUN
    } div_state_e;

    // true when the ratio leaves the supported 1:2 .. 2:1 window
    function automatic logic ratio_outside(input ratio_t q);
        return (q < RATIO_HALF) || (q > RATIO_TWO);
    endfunction

endpackage

// File: rtl/rt_edge_sync.sv
module rt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    // STAGES synchronizer flops followed by one history flop
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], async_i};
        end
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/rt_period_avg.sv
module rt_period_avg #(
    parameter int CNT_W      = 12,
    parameter int FRAC       = 8,
    parameter int SLOW_SHIFT = 6,
    parameter int FAST_SHIFT = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  event_i,
    input  logic                  fast_i,
    output logic [CNT_W+FRAC-1:0] avg_o,
    output logic                  loaded_o,
    output logic                  upd_o
);
    localparam int FILT_W = CNT_W + FRAC;
    localparam int DIFF_W = FILT_W + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]         cnt_q;
    logic                     armed_q;
    logic [CNT_W-1:0]         sample;
    logic [FILT_W-1:0]        target;
    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] step;
    logic signed [DIFF_W-1:0] blend;
    int unsigned              shamt;

    // a period that would overflow the counter is clipped to its maximum
    assign sample = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    assign target = FILT_W'(sample) << FRAC;
    assign shamt  = fast_i ? FAST_SHIFT : SLOW_SHIFT;

    always_comb begin
        diff  = $signed({2'b00, target}) - $signed({2'b00, avg_o});
        step  = diff >>> shamt;
        blend = $signed({2'b00, avg_o}) + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            armed_q  <= 1'b0;
            loaded_o <= 1'b0;
            avg_o    <= '0;
            upd_o    <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            if (event_i) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
                if (armed_q) begin
                    upd_o    <= 1'b1;
                    loaded_o <= 1'b1;
                    avg_o    <= loaded_o ? blend[FILT_W-1:0] : target;
                end
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rt_ratio_div.sv
module rt_ratio_div
    import ratio_trk_pkg::*;
#(
    parameter int NUM_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [NUM_W-1:0] den_i,
    output logic             done_o,
    output ratio_res_t       res_o
);
    localparam int QW = NUM_W + RATIO_FRAC;
    localparam int CW = $clog2(QW);

    div_state_e        state_q;
    logic [NUM_W-1:0]  rem_q;
    logic [NUM_W-1:0]  den_q;
    logic [QW-1:0]     dsr_q;
    logic [QW-1:0]     quo_q;
    logic [CW-1:0]     iter_q;

    logic [NUM_W:0]    trial;
    logic              fits;
    logic [NUM_W:0]    rem_nxt;
    logic [QW-1:0]     quo_nxt;
    logic              sat;
    ratio_t            value;

    always_comb begin
        trial   = {rem_q, dsr_q[QW-1]};
        fits    = trial >= {1'b0, den_q};
        rem_nxt = fits ? trial - {1'b0, den_q} : trial;
        quo_nxt = {quo_q[QW-2:0], fits};
        sat     = |quo_nxt[QW-1:RATIO_W];
        value   = sat ? RATIO_SAT : quo_nxt[RATIO_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            rem_q   <= '0;
            den_q   <= '0;
            dsr_q   <= '0;
            quo_q   <= '0;
            iter_q  <= '0;
            done_o  <= 1'b0;
            res_o   <= '0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                DIV_IDLE: begin
                    if (start_i) begin
                        rem_q   <= '0;
                        den_q   <= den_i;
                        dsr_q   <= QW'(num_i) << RATIO_FRAC;
                        quo_q   <= '0;
                        iter_q  <= '0;
                        state_q <= DIV_RUN;
                    end
                end
                DIV_RUN: begin
                    rem_q  <= rem_nxt[NUM_W-1:0];
                    dsr_q  <= dsr_q << 1;
                    quo_q  <= quo_nxt;
                    iter_q <= iter_q + 1'b1;
                    if (iter_q == CW'(QW - 1)) begin
                        state_q <= DIV_IDLE;
                        done_o  <= 1'b1;
                        res_o   <= '{value: value, outside: ratio_outside(value)};
                    end
                end
                default: state_q <= DIV_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ratio_tracker.sv
module ratio_tracker
    import ratio_trk_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int FILT_FRAC   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SLOW_SHIFT  = 6,
    parameter int FAST_SHIFT  = 4,
    parameter int VALID_COUNT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_in_i,
    input  logic               frame_out_i,
    input  logic               fast_settle_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               ratio_valid_o,
    output logic               out_of_range_o
);
    localparam int FILT_W = CNT_W + FILT_FRAC;
    localparam int VCW    = $clog2(VALID_COUNT + 1);
    localparam int CH_IN  = 0;
    localparam int CH_OUT = 1;

    logic [1:0]        frames;
    logic [1:0]        rise;
    logic [1:0]        loaded;
    logic [1:0]        upd;
    logic [FILT_W-1:0] avg_q [2];
    logic [FILT_W-1:0] in_avg;
    logic [FILT_W-1:0] out_avg;

    logic              div_start;
    logic              div_done;
    ratio_res_t        div_res;

    logic [VCW-1:0]    res_cnt_q;
    logic [VCW-1:0]    res_cnt_nxt;
    logic              valid_nxt;

    assign frames = {frame_out_i, frame_in_i};

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        rt_edge_sync #(
            .STAGES(SYNC_STAGES)
        ) sync_i (
            .clk    (clk),
            .rst    (rst),
            .async_i(frames[ch]),
            .rise_o (rise[ch])
        );

        rt_period_avg #(
            .CNT_W     (CNT_W),
            .FRAC      (FILT_FRAC),
            .SLOW_SHIFT(SLOW_SHIFT),
            .FAST_SHIFT(FAST_SHIFT)
        ) avg_i (
            .clk     (clk),
            .rst     (rst),
            .event_i (rise[ch]),
            .fast_i  (fast_settle_i),
            .avg_o   (avg_q[ch]),
            .loaded_o(loaded[ch]),
            .upd_o   (upd[ch])
        );
    end

    assign in_avg  = avg_q[CH_IN];
    assign out_avg = avg_q[CH_OUT];

    // one division per output frame, once both averages hold a period
    assign div_start = upd[CH_OUT] & loaded[CH_IN] & loaded[CH_OUT];

    rt_ratio_div #(
        .NUM_W(FILT_W)
    ) div_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(div_start),
        .num_i  (out_avg),
        .den_i  (in_avg),
        .done_o (div_done),
        .res_o  (div_res)
    );

    always_comb begin
        res_cnt_nxt = res_cnt_q;
        if (res_cnt_q != VCW'(VALID_COUNT)) begin
            res_cnt_nxt = res_cnt_q + 1'b1;
        end
        valid_nxt = (res_cnt_nxt == VCW'(VALID_COUNT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_cnt_q      <= '0;
            ratio_o        <= '0;
            ratio_valid_o  <= 1'b0;
            out_of_range_o <= 1'b0;
        end else if (div_done) begin
            res_cnt_q      <= res_cnt_nxt;
            ratio_o        <= div_res.value;
            ratio_valid_o  <= valid_nxt;
            out_of_range_o <= div_res.outside & valid_nxt;
        end
    end

endmodule

// File: rtl/rt_checker.sv
module rt_checker
    import ratio_trk_pkg::*;
#(
    parameter int FILT_W = 20,
    parameter int FRAC   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [RATIO_W-1:0] ratio,
    input logic              valid,
    input logic              oor,
    input logic              div_done,
    input logic [FILT_W-1:0] in_avg,
    input logic [FILT_W-1:0] out_avg
);
    localparam logic [FILT_W-1:0] CEIL = ({FILT_W{1'b1}} >> FRAC) << FRAC;

    p_oor_gated_r9: assert property (@(posedge clk) disable iff (rst)
        oor |-> valid);

    p_oor_window_r9: assert property (@(posedge clk) disable iff (rst)
        valid |-> (oor == ((ratio < RATIO_HALF) || (ratio > RATIO_TWO))));

    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    p_valid_after_result_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> $past(div_done));

    p_ratio_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(div_done) |-> $stable(ratio));

    p_in_avg_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        in_avg <= CEIL);

    p_out_avg_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
        out_avg <= CEIL);

endmodule

bind ratio_tracker rt_checker #(
    .FILT_W(FILT_W),
    .FRAC  (FILT_FRAC)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .ratio   (ratio_o),
    .valid   (ratio_valid_o),
    .oor     (out_of_range_o),
    .div_done(div_done),
    .in_avg  (in_avg),
    .out_avg (out_avg)
);

// File: tb/ratio_tracker_tb_top.sv
module ratio_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fin = 1'b0;
    logic        fout = 1'b0;
    logic        fast_mode = 1'b0;
    logic [21:0] ratio;
    logic        valid;
    logic        oor;

    int nchk = 0;
    int nerr = 0;

    int ph_i = 0, cur_i = 100, nxt_i = 100;
    int ph_o = 0, cur_o = 100, nxt_o = 100;
    int edges_o = 0;
    bit gen_hold = 1'b1;

    always #4 clk = ~clk;

    ratio_tracker dut_i (
        .clk           (clk),
        .rst           (rst),
        .frame_in_i    (fin),
        .frame_out_i   (fout),
        .fast_settle_i (fast_mode),
        .ratio_o       (ratio),
        .ratio_valid_o (valid),
        .out_of_range_o(oor)
    );

    // frame clock generators, period counted in master cycles
    always @(negedge clk) begin
        if (gen_hold) begin
            ph_i = 0; cur_i = nxt_i; fin = 1'b0;
        end else begin
            if (ph_i == 0) cur_i = nxt_i;
            fin  = (ph_i < cur_i / 2);
            ph_i = (ph_i + 1 >= cur_i) ? 0 : ph_i + 1;
        end
    end

    always @(negedge clk) begin
        if (gen_hold) begin
            ph_o = 0; cur_o = nxt_o; fout = 1'b0;
        end else begin
            if (ph_o == 0) begin
                cur_o = nxt_o;
                edges_o = edges_o + 1;
            end
            fout = (ph_o < cur_o / 2);
            ph_o = (ph_o + 1 >= cur_o) ? 0 : ph_o + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_ratio(input int pin, input int pout);
        longint mi = (pin > 4095) ? 4095 : pin;
        longint mo = (pout > 4095) ? 4095 : pout;
        longint q  = (mo << 20) / mi;
        return (q > 64'h3FFFFF) ? 64'h3FFFFF : q;
    endfunction

    function automatic bit exp_oor(input longint q);
        return (q < 64'h80000) || (q > 64'h200000);
    endfunction

    task automatic start_run(input int pin, input int pout, input bit fast);
        rst = 1'b1;
        gen_hold = 1'b1;
        nxt_i = pin;
        nxt_o = pout;
        fast_mode = fast;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        gen_hold = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(edges_o);
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
    endtask

    task automatic steady(input string req, input int pin, input int pout, input bit fast);
        longint q;
        start_run(pin, pout, fast);
        wait_edges(10);
        settle();
        q = exp_ratio(pin, pout);
        chk(req, ratio, q);
        chk("R8 valid", valid, 1);
        chk("R9 range flag", oor, exp_oor(q));
    endtask

    task automatic step_run(input bit fast);
        longint f, q;
        int k;
        start_run(200, 200, fast);
        wait_edges(10);
        settle();
        chk("R4 pre-step", ratio, 64'h100000);
        @(edges_o);
        nxt_o = 300;
        @(edges_o);
        wait_edges(8);
        settle();
        k = fast ? 4 : 6;
        f = 200 * 256;
        for (int n = 0; n < 8; n++) f = f + ((300 * 256 - f) >> k);
        q = (f << 20) / (200 * 256);
        chk(fast ? "R4 fast step" : "R4 slow step", ratio, q);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5821));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ratio", ratio, 0);
        chk("R1 valid", valid, 0);
        chk("R1 range", oor, 0);

        // R3 / R5 / R8: start-up sequence with equal periods
        start_run(150, 150, 1'b0);
        @(edges_o);
        settle();
        chk("R5 no ratio before load", ratio, 0);
        chk("R1 valid after release", valid, 0);
        @(edges_o);
        settle();
        chk("R3 first period loaded directly", ratio, 64'h100000);
        chk("R8 not valid after one result", valid, 0);
        wait_edges(5);
        settle();
        chk("R8 valid after four results", valid, 1);
        chk("R9 unity in range", oor, 0);

        // R2: directed ratios
        steady("R2 ratio 1.0", 150, 150, 1'b1);
        steady("R2 ratio 1.5", 120, 180, 1'b0);
        steady("R9 exact 2.0", 100, 200, 1'b0);
        steady("R9 exact 0.5", 200, 100, 1'b1);
        steady("R9 below 0.5", 250, 100, 1'b0);
        steady("R9 ratio 3.0", 80, 240, 1'b0);
        steady("R6 saturation", 60, 300, 1'b1);
        steady("R7 long period clip", 4500, 2250, 1'b0);

        // R2: random ratios inside the window
        for (int n = 0; n < 8; n++) begin
            int pin, pout;
            pin  = 100 + int'($urandom % 180);
            pout = pin / 2 + int'($urandom % (pin * 3 / 2 + 1));
            if (pout < 60) pout = 60;
            steady("R2 random", pin, pout, n[0]);
        end

        // R4: step response in both settling modes
        step_run(1'b0);
        step_run(1'b1);

        // R1: reset again after a run
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 ratio after rerun", ratio, 0);
        chk("R1 valid after rerun", valid, 0);
        chk("R1 range after rerun", oor, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule